// File: doc/BRIEF.md
# Synchronous Shift-Mode Serial Port

This block moves one byte in each direction over a clocked serial link. A host places a byte on the parallel input and pulses a start strobe. The block then drives a shift clock that it derives from the system clock. It shifts the byte out on a transmit line, least significant bit first, and samples eight bits from a receive line during the same frame. There are no start, stop or parity bits.

Each period of the shift clock lasts six system cycles: three cycles low, then three cycles high. A transmitted bit changes one system cycle after each rising edge of the shift clock. The next bit is therefore stable well before the following rising edge. The receive line is sampled on the rising edge.

When the frame ends, the busy flag drops and a one-cycle completion pulse marks the moment the received byte becomes valid. Between frames the shift clock and the transmit line rest high.

Top module: `sync_shift_port`

## Requirements
- R1: After a synchronous reset, the outputs are: busy low, done low, shift clock high, transmit line high and received byte 0x00.
- R2: A start strobe seen while idle loads the input byte. Busy is high from the next cycle.
- R3: The shift clock goes low in the cycle after the start is accepted. It stays low for three cycles and then high for three cycles, which gives a six-cycle period.
- R4: A frame has exactly eight rising edges of the shift clock. While idle, both the shift clock and the transmit line are held high.
- R5: Bits leave least significant first. Bit 0 is on the line from the first cycle of the frame. The line advances to the next bit one cycle after each rising edge and stays constant in every other cycle.
- R6: The receive line is sampled at each rising edge of the shift clock. The first sample lands in bit 0 of the received byte and the eighth sample lands in bit 7.
- R7: One cycle after the eighth rising edge, busy drops and done is high for exactly one cycle. The received byte updates in that same cycle and holds until the next frame completes. Busy lasts 46 cycles per frame.
- R8: A start strobe seen while busy is ignored. The frame in progress and its data are unaffected, and no second frame follows.
- R9: A reset in the middle of a frame returns the block to the idle state described in R1 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe for a frame |
| tx_byte_i | input | 8 | Byte to transmit, sampled with an accepted start |
| rxd_i | input | 1 | Serial receive line |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle pulse when a frame completes |
| rx_byte_o | output | 8 | Last received byte, first bit in bit 0 |
| sclk_o | output | 1 | Shift clock, idles high |
| txd_o | output | 1 | Serial transmit line, idles high |

## Verification
Two corner cases are hard to reach from the ports: a start pulse that arrives while a frame is running, and a start pulse that arrives in the exact completion cycle. The stimulus places one strobe in the middle of a frame and another in the cycle where done is high. This checks that the first is dropped and the second starts a new frame at once. The receive line changes value every cycle, driven from a pseudo-random sequence. Because of that, sampling one cycle early or late produces a wrong received byte. A reset placed in the middle of a frame exercises recovery to idle.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int SSP_DATA_W_DEF = 8;
    localparam int SSP_HALF_DEF   = 3;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } ssp_phase_e;

endpackage

// File: rtl/ssp_clk_phase.sv
module ssp_clk_phase #(
    parameter int HALF_CYCLES = ssp_pkg::SSP_HALF_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o
);
    import ssp_pkg::*;

    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    typedef struct packed {
        ssp_phase_e    ph;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d  = tmr_q;
        rise_o = 1'b0;
        if (load_i) begin
            tmr_d.ph  = PH_LOW;
            tmr_d.cnt = '0;
        end else if (run_i) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.cnt = '0;
                tmr_d.ph  = (tmr_q.ph == PH_LOW) ? PH_HIGH : PH_LOW;
                rise_o    = (tmr_q.ph == PH_LOW);
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end else begin
            tmr_d.ph  = PH_HIGH;
            tmr_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q.ph  <= PH_HIGH;
            tmr_q.cnt <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign sclk_o = (tmr_q.ph == PH_HIGH);

    AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !load_i) |=> sclk_o) else $error("idle clock not high"); // R4

    AST_LOAD_GOES_LOW: assert property (@(posedge clk) disable iff (rst)
        load_i |=> !sclk_o) else $error("clock not low after load"); // R3

endmodule

// File: rtl/ssp_shift_lane.sv
module ssp_shift_lane #(
    parameter int DATA_W = ssp_pkg::SSP_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              adv_i,
    input  logic              sample_i,
    input  logic              rxd_i,
    output logic              tx_bit_o,
    output logic [DATA_W-1:0] rx_word_o
);

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } lane_t;

    lane_t lane_q, lane_d;

    always_comb begin
        lane_d = lane_q;
        if (load_i) begin
            lane_d.tx = data_i;
            lane_d.rx = '0;
        end else begin
            if (adv_i) begin
                lane_d.tx = {1'b1, lane_q.tx[DATA_W-1:1]};
            end
            if (sample_i) begin
                lane_d.rx = {rxd_i, lane_q.rx[DATA_W-1:1]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign tx_bit_o  = lane_q.tx[0];
    assign rx_word_o = lane_q.rx;

    AST_LOAD_TAKES_BYTE: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (tx_bit_o == $past(data_i[0]))) else $error("bit 0 not loaded"); // R5

endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
    parameter int DATA_W      = ssp_pkg::SSP_DATA_W_DEF,
    parameter int HALF_CYCLES = ssp_pkg::SSP_HALF_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              rxd_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              sclk_o,
    output logic              txd_o
);

    localparam int BW = $clog2(DATA_W);
    localparam logic [BW-1:0] LASTBIT = BW'(DATA_W - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              adv;
        logic [BW-1:0]     bitcnt;
        logic [DATA_W-1:0] rxo;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic              load;
    logic              rise;
    logic              tx_bit;
    logic [DATA_W-1:0] rx_word;

    assign load = start_i & ~ctl_q.busy;

    ssp_clk_phase #(
        .HALF_CYCLES(HALF_CYCLES)
    ) u_phase (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .run_i  (ctl_q.busy),
        .sclk_o (sclk_o),
        .rise_o (rise)
    );

    ssp_shift_lane #(
        .DATA_W(DATA_W)
    ) u_lane (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .data_i    (tx_byte_i),
        .adv_i     (ctl_q.adv & ctl_q.busy),
        .sample_i  (rise),
        .rxd_i     (rxd_i),
        .tx_bit_o  (tx_bit),
        .rx_word_o (rx_word)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.adv  = rise;
        if (load) begin
            ctl_d.busy   = 1'b1;
            ctl_d.bitcnt = '0;
        end else if (ctl_q.busy && ctl_q.adv) begin
            if (ctl_q.bitcnt == LASTBIT) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
                ctl_d.rxo  = rx_word;
            end else begin
                ctl_d.bitcnt = ctl_q.bitcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o    = ctl_q.busy;
    assign done_o    = ctl_q.done;
    assign rx_byte_o = ctl_q.rxo;
    assign txd_o     = ctl_q.busy ? tx_bit : 1'b1;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R7

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o))) else $error("done without busy end"); // R7

    AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (sclk_o && txd_o)) else $error("idle lines not high"); // R4

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && !(ctl_q.adv && ctl_q.bitcnt == LASTBIT)) |=> busy_o)
        else $error("start while busy disturbed frame"); // R8

    AST_TXD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o) && !$past(ctl_q.adv)) |-> $stable(txd_o))
        else $error("txd moved outside advance cycle"); // R5

    AST_BUSY_RAISE: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o) else $error("idle start not taken"); // R2

endmodule

// File: tb/sync_shift_port_tb.sv
module sync_shift_port_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [7:0] tx_byte;
    logic       rxd;
    logic       busy, done, sclk, txd;
    logic [7:0] rx_byte;

    always #2 clk = ~clk;

    sync_shift_port dut_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .tx_byte_i (tx_byte),
        .rxd_i     (rxd),
        .busy_o    (busy),
        .done_o    (done),
        .rx_byte_o (rx_byte),
        .sclk_o    (sclk),
        .txd_o     (txd)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    // receive stimulus: changes every cycle
    logic [15:0] lf = 16'hACE1;
    always @(negedge clk) lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    assign rxd = lf[0];

    // behavioural reference model
    bit       started = 0;
    bit       m_busy = 0, m_done = 0;
    int       t = 0;
    bit [7:0] m_tx = 0, m_acc = 0, m_rx = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; t = 0; m_acc = 0; m_rx = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                t = t + 1;
                if (t >= 3 && t <= 45 && ((t - 3) % 6) == 0) m_acc[(t - 3) / 6] = rxd;
                if (t == 46) begin
                    m_busy = 0; m_done = 1; m_rx = m_acc;
                end
            end else if (start) begin
                m_busy = 1; t = 0; m_acc = 0; m_tx = tx_byte;
            end
        end
        started = 1;
    end

    // per-cycle comparison and frame statistics
    int  rises = 0, busy_len = 0;
    bit  prev_sclk = 1;

    always @(negedge clk) begin
        if (started) begin
            int idx;
            int exp_sclk, exp_txd;
            idx = (t >= 4) ? ((t - 4) / 6 + 1) : 0;
            if (idx > 7) idx = 7;
            exp_sclk = m_busy ? (((t / 3) % 2) == 1) : 1;
            exp_txd  = m_busy ? m_tx[idx] : 1;
            chk("R3", "sclk",    sclk,    exp_sclk);
            chk("R5", "txd",     txd,     exp_txd);
            chk("R2", "busy",    busy,    m_busy);
            chk("R7", "done",    done,    m_done);
            chk("R6", "rx_byte", rx_byte, m_rx);
        end
        if (rst) begin
            rises = 0; busy_len = 0; prev_sclk = 1;
        end else begin
            if (busy) busy_len++;
            if (busy && sclk && !prev_sclk) rises++;
            if (done) begin
                chk("R4", "rising edges per frame", rises, 8);
                chk("R7", "busy length", busy_len, 46);
                rises = 0; busy_len = 0;
            end
            prev_sclk = sclk;
        end
    end

    task automatic send(input logic [7:0] b);
        start   <= 1'b1;
        tx_byte <= b;
        @(negedge clk);
        start   <= 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (done) break;
        end
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; tx_byte = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy",    busy,    0);
        chk("R1", "done",    done,    0);
        chk("R1", "sclk",    sclk,    1);
        chk("R1", "txd",     txd,     1);
        chk("R1", "rx_byte", rx_byte, 0);
        rst <= 1'b0;
        @(negedge clk);

        send(8'hA5);
        chk("R2", "busy after start", busy, 1);
        wait_done();
        @(negedge clk);

        // R8: start during a frame is dropped
        send(8'h3C);
        repeat (10) @(negedge clk);
        send(8'hFF);
        chk("R8", "busy kept", busy, 1);
        wait_done();
        @(negedge clk);
        @(negedge clk);
        chk("R8", "no second frame", busy, 0);

        // start in the completion cycle
        send(8'h81);
        wait_done();
        send(8'h6E);
        chk("R2", "start at done cycle accepted", busy, 1);
        wait_done();
        @(negedge clk);

        // R9: reset mid-frame
        send(8'hC3);
        repeat (20) @(negedge clk);
        rst <= 1'b1;
        @(negedge clk);
        rst <= 1'b0;
        chk("R9", "busy",    busy,    0);
        chk("R9", "sclk",    sclk,    1);
        chk("R9", "txd",     txd,     1);
        chk("R9", "done",    done,    0);
        chk("R9", "rx_byte", rx_byte, 0);
        @(negedge clk);

        send(8'h00);
        wait_done();
        @(negedge clk);
        send(8'hFF);
        wait_done();
        repeat (4) @(negedge clk);
        chk("R4", "idle sclk", sclk, 1);
        chk("R7", "rx held after frame", rx_byte, m_rx);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk("WATCHDOG", "run completed", 0, 1);
        finish_run();
    end

endmodule